// File: doc/BRIEF.md
# Reset Cause and Supply Warning Register

This block is an 8-bit control and status register that a CPU reads and writes over a simple byte-wide register port. Its main job is to remember what caused the most recent reset. It keeps two sticky flags, one for a watchdog reset and one for a low-voltage reset. When neither flag is set, the reset came from the external pin.

Both flags live in a storage domain that only power-on clears. The ordinary system reset leaves them untouched. The reset generator tells the block about a reset event with a one-cycle strobe per cause.

The same register also carries three other things. It shows a live supply-warning flag, taken from a comparator level and sampled once per clock. It holds an interrupt enable for that warning, and the block raises an interrupt request while the warning is set and the enable is on. Finally, it holds a 2-bit oscillator trim field, which comes up as 11 after every system reset.

The bus port is a plain register access, not a stream. A write or a read takes effect in the single clock cycle in which `bus_sel` is high together with `bus_wr` or `bus_rd`. No back-pressure exists: every access completes in that cycle. Read data is combinational from the current register state. Accesses made while `rst_n` is low are ignored.

Top module: `rst_cause_reg`

## Requirements
- R1: After power-on (`por_n` low) followed by system reset (`rst_n` low), the register reads 8'h60: trim bits [6:5] = 11, and every other bit is 0.
- R2: A one-cycle `evt_wdg` strobe sets the watchdog flag (bit 4), which is visible from the next cycle.
- R3: Writing 0 to bit 4 clears the watchdog flag. Writing 1 to bit 4 leaves it unchanged. When `evt_wdg` and a clearing write happen in the same cycle, the flag ends up set.
- R4: An `evt_lvd` strobe sets the low-voltage flag (bit 2) and clears the watchdog flag in the same update. This holds even when `evt_wdg` arrives in the same cycle.
- R5: A register read clears the low-voltage flag in the next cycle. When the read and `evt_lvd` happen in the same cycle, the flag stays set.
- R6: A system reset (`rst_n` low) changes neither the watchdog flag nor the low-voltage flag.
- R7: Bit 1 holds `warn_lvl` as sampled at the previous clock edge. Writes to bit 1 have no effect.
- R8: `irq` is 1 exactly when bit 1 (warning) and bit 0 (interrupt enable) are both 1.
- R9: Bits 7 and 3 always read 0, whatever value is written to them.
- R10: `src_code` encodes the reset cause as follows: 2'b10 whenever the low-voltage flag is set; otherwise 2'b01 when the watchdog flag is set; otherwise 2'b00 (external pin).
- R11: A write loads bits [6:5] (trim) and bit 0 (interrupt enable) from `bus_wdata`, and they read back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear for the reset flags, active low, asynchronous |
| rst_n | input | 1 | System reset for trim, enable and warning, active low, asynchronous |
| evt_wdg | input | 1 | One-cycle strobe: watchdog reset occurred |
| evt_lvd | input | 1 | One-cycle strobe: low-voltage reset occurred |
| warn_lvl | input | 1 | Supply-warning comparator level, 1 = below threshold |
| bus_sel | input | 1 | Register selected |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the low-voltage flag) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Supply-warning interrupt request |
| src_code | output | 2 | Decoded reset source |

## Verification
Two pairs of functions can act on the same flag in one cycle. The first pair is the hardware set of the low-voltage flag and the read-clear of that flag. The second pair is the watchdog set and the software write of 0 to the watchdog flag; the low-voltage event's clear of the watchdog flag also competes in this pair. The bench provokes each collision with directed cycles that drive the event strobe together with the bus access. It then checks that the flag ends up set, or cleared in the case of a low-voltage event. Random traffic then overlaps strobes, reads, writes and system resets, and a bench model that applies the stated priorities judges every cycle.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int REG_W   = 8;
  localparam int TRIM_W  = 2;
  localparam int SRC_W   = 2;
  localparam int B_TRIM  = 5;
  localparam int B_WDG   = 4;
  localparam int B_LVD   = 2;
  localparam int B_WARN  = 1;
  localparam int B_IEN   = 0;

  typedef enum logic [SRC_W-1:0] {
    SRC_PIN = 2'b00,
    SRC_WDG = 2'b01,
    SRC_LVD = 2'b10
  } src_e;

  typedef struct packed {
    logic wdg;
    logic lvd;
  } flags_t;

  typedef struct packed {
    logic [TRIM_W-1:0] trim;
    logic              ien;
    logic              warn;
  } ctrl_t;
endpackage

// File: rtl/rcr_flags.sv
module rcr_flags
  import rcr_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   evt_wdg,
  input  logic   evt_lvd,
  input  logic   clr_wdg,
  input  logic   rd_clr,
  output flags_t flags
);
  flags_t nxt;

  always_comb begin
    nxt = flags;
    // low-voltage event dominates the watchdog flag
    if (evt_lvd)      nxt.wdg = 1'b0;
    else if (evt_wdg) nxt.wdg = 1'b1;
    else if (clr_wdg) nxt.wdg = 1'b0;
    // a set beats the read-clear
    if (evt_lvd)      nxt.lvd = 1'b1;
    else if (rd_clr)  nxt.lvd = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flags <= '0;
    else        flags <= nxt;
  end

  // R4
  lvd_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt_lvd |=> (flags.lvd && !flags.wdg));
  // R5
  rd_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_clr && !evt_lvd) |=> !flags.lvd);
  // R3
  wdg_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!evt_lvd && !evt_wdg && !clr_wdg) |=> $stable(flags.wdg));
  // R2
  wdg_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (evt_wdg && !evt_lvd) |=> flags.wdg);
endmodule

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter logic [TRIM_W-1:0] TRIM_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             warn_lvl,
  output ctrl_t            ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.trim <= TRIM_INIT;
      ctrl.ien  <= 1'b0;
      ctrl.warn <= 1'b0;
    end else begin
      ctrl.warn <= warn_lvl;
      if (wr_en) begin
        ctrl.trim <= wdata[B_TRIM +: TRIM_W];
        ctrl.ien  <= wdata[B_IEN];
      end
    end
  end

  // R11
  trim_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl.trim) && $stable(ctrl.ien));
endmodule

// File: rtl/rcr_view.sv
module rcr_view
  import rcr_pkg::*;
(
  input  flags_t           flags,
  input  ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata,
  output logic             irq,
  output logic [SRC_W-1:0] src
);
  always_comb begin
    rdata                      = '0;
    rdata[B_TRIM +: TRIM_W]    = ctrl.trim;
    rdata[B_WDG]               = flags.wdg;
    rdata[B_LVD]               = flags.lvd;
    rdata[B_WARN]              = ctrl.warn;
    rdata[B_IEN]               = ctrl.ien;
  end

  assign irq = ctrl.warn & ctrl.ien;

  always_comb begin
    if (flags.lvd)      src = SRC_LVD;
    else if (flags.wdg) src = SRC_WDG;
    else                src = SRC_PIN;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter logic [TRIM_W-1:0] TRIM_INIT = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             evt_wdg,
  input  logic             evt_lvd,
  input  logic             warn_lvl,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq,
  output logic [SRC_W-1:0] src_code
);
  flags_t flags;
  ctrl_t  ctrl;
  logic   wr_ok, rd_ok;

  assign wr_ok = bus_sel & bus_wr & rst_n;
  assign rd_ok = bus_sel & bus_rd & rst_n;

  rcr_flags u_flags (
    .clk     (clk),
    .por_n   (por_n),
    .evt_wdg (evt_wdg),
    .evt_lvd (evt_lvd),
    .clr_wdg (wr_ok & ~bus_wdata[B_WDG]),
    .rd_clr  (rd_ok),
    .flags   (flags)
  );

  rcr_ctrl #(.TRIM_INIT(TRIM_INIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .wdata    (bus_wdata),
    .warn_lvl (warn_lvl),
    .ctrl     (ctrl)
  );

  rcr_view u_view (
    .flags (flags),
    .ctrl  (ctrl),
    .rdata (bus_rdata),
    .irq   (irq),
    .src   (src_code)
  );

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (bus_rdata[B_WARN] && bus_rdata[B_IEN]));
  // R10
  lvd_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[B_LVD] |-> (src_code == SRC_LVD));
  // R6
  flag_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !evt_wdg && !evt_lvd) |=> $stable(flags));
endmodule

// File: tb/tb_rst_cause_reg.sv
`timescale 1ns/1ps
module tb_rst_cause_reg;
  logic clk = 1'b0;
  logic por_n, rst_n, evt_wdg, evt_lvd, warn_lvl, bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic irq;
  logic [1:0] src_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model state
  logic m_wdg, m_lvd, m_ien, m_warn;
  logic [1:0] m_trim;

  always #2.5 clk = ~clk;

  rst_cause_reg dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .evt_wdg(evt_wdg), .evt_lvd(evt_lvd),
    .warn_lvl(warn_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .src_code(src_code)
  );

  function automatic logic [7:0] exp_rd();
    return {1'b0, m_trim, m_wdg, 1'b0, m_lvd, m_warn, m_ien};
  endfunction

  function automatic logic [1:0] exp_src();
    return m_lvd ? 2'b10 : (m_wdg ? 2'b01 : 2'b00);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_rd();
    chk(bus_rdata[6:5] == e[6:5] && bus_rdata[0] == e[0], "R11 trim/ien", bus_rdata, e);
    chk(bus_rdata[4] == e[4], "R3 watchdog flag", bus_rdata, e);
    chk(bus_rdata[2] == e[2], "R5 low-voltage flag", bus_rdata, e);
    chk(bus_rdata[1] == e[1], "R7 warning flag", bus_rdata, e);
    chk(bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0, "R9 reserved bits", bus_rdata, e);
    chk(irq == (m_warn & m_ien), "R8 irq", {7'd0, irq}, {7'd0, m_warn & m_ien});
    chk(src_code == exp_src(), "R10 source code", {6'd0, src_code}, {6'd0, exp_src()});
  endtask

  // apply inputs at a negedge, update model, check at the following negedge
  task automatic step(input logic sel, input logic wr, input logic rd, input logic [7:0] wd,
                      input logic ew, input logic el, input logic wl, input logic rn);
    logic acc_wr, acc_rd;
    bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    evt_wdg = ew; evt_lvd = el; warn_lvl = wl; rst_n = rn;
    acc_wr = sel & wr & rn;
    acc_rd = sel & rd & rn;
    if (el)                        m_wdg = 1'b0;
    else if (ew)                   m_wdg = 1'b1;
    else if (acc_wr && !wd[4])     m_wdg = 1'b0;
    if (el)                        m_lvd = 1'b1;
    else if (acc_rd)               m_lvd = 1'b0;
    if (!rn) begin
      m_trim = 2'b11; m_ien = 1'b0; m_warn = 1'b0;
    end else begin
      m_warn = wl;
      if (acc_wr) begin m_trim = wd[6:5]; m_ien = wd[0]; end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check_all();
  endtask

  task automatic idle(input logic wl);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, wl, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    por_n = 1'b0; rst_n = 1'b0;
    evt_wdg = 0; evt_lvd = 0; warn_lvl = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    m_wdg = 0; m_lvd = 0; m_trim = 2'b11; m_ien = 0; m_warn = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    step(0, 0, 0, 8'h00, 0, 0, 0, 0);
    idle(0);
    // R1 reset state
    chk(bus_rdata == 8'h60, "R1 reset value", bus_rdata, 8'h60);
    chk(src_code == 2'b00, "R1 source after power-on", {6'd0, src_code}, 8'h00);

    // R2 watchdog event
    step(0, 0, 0, 8'h00, 1, 0, 0, 1);
    chk(bus_rdata[4] == 1'b1, "R2 watchdog set", bus_rdata, 8'h70);
    chk(src_code == 2'b01, "R10 watchdog source", {6'd0, src_code}, 8'h01);

    // R6 system reset keeps flags
    step(0, 0, 0, 8'h00, 0, 0, 0, 0);
    idle(0);
    chk(bus_rdata == 8'h70, "R6 watchdog survives reset", bus_rdata, 8'h70);

    // R3 write 1 keeps, write 0 with concurrent set keeps, write 0 clears
    step(1, 1, 0, 8'h70, 0, 0, 0, 1);
    chk(bus_rdata[4] == 1'b1, "R3 write one no effect", bus_rdata, 8'h70);
    step(1, 1, 0, 8'h60, 1, 0, 0, 1);
    chk(bus_rdata[4] == 1'b1, "R3 set beats write zero", bus_rdata, 8'h70);
    step(1, 1, 0, 8'h60, 0, 0, 0, 1);
    chk(bus_rdata[4] == 1'b0, "R3 write zero clears", bus_rdata, 8'h60);

    // R4 lvd with concurrent watchdog event
    step(0, 0, 0, 8'h00, 1, 1, 0, 1);
    chk(bus_rdata[4] == 1'b0 && bus_rdata[2] == 1'b1, "R4 lvd sets and clears watchdog", bus_rdata, 8'h64);
    step(0, 0, 0, 8'h00, 1, 0, 0, 0);
    idle(0);
    chk(bus_rdata == 8'h74, "R6 lvd survives reset", bus_rdata, 8'h74);
    chk(src_code == 2'b10, "R10 lvd dominates", {6'd0, src_code}, 8'h02);

    // R5 read-clear against a set
    step(1, 0, 1, 8'h00, 0, 1, 0, 1);
    chk(bus_rdata[2] == 1'b1, "R5 set beats read clear", bus_rdata, 8'h64);
    step(1, 0, 1, 8'h00, 0, 0, 0, 1);
    chk(bus_rdata[2] == 1'b0, "R5 read clears", bus_rdata, 8'h60);

    // R9 / R7 / R11 write all ones
    step(1, 1, 0, 8'hFF, 0, 0, 0, 1);
    chk(bus_rdata == 8'h61, "R9 reserved and warning ignore writes", bus_rdata, 8'h61);
    step(0, 0, 0, 8'h00, 0, 0, 1, 1);
    chk(bus_rdata[1] == 1'b1 && irq, "R8 irq on warning with enable", bus_rdata, 8'h63);
    step(1, 1, 0, 8'h00, 0, 0, 1, 1);
    chk(!irq && bus_rdata[6:5] == 2'b00, "R11 trim/ien write", bus_rdata, 8'h02);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] | r[1], r[1] & r[2], r[3] & r[4] & r[0], 8'($urandom),
           ($urandom % 16) == 0, ($urandom % 23) == 0, ($urandom % 3) == 0,
           ($urandom % 40) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule